// File: doc/BRIEF.md
# Product-Data Image CRC-32 Engine

This block computes the 32-bit checksum of a non-volatile product-data image, one byte per clock. A frame opens on a beat that carries the start marker and closes on a beat that carries the last marker. Every accepted byte is folded into a 32-bit register with the 0x04C11DB7 polynomial. The register shifts toward its top bit, while the data bits of each byte go in least significant bit first. When the frame closes, the register is bit-reversed and inverted, and the result appears on `crc_o` together with a one-cycle `done_o` pulse.

The same engine serves both to check an image and to generate its checksum. The image holds its own checksum in a four-byte field, and those bytes must count as zero while the sum is formed. To do that, the caller raises `mask_i` on those four beats and the engine uses 0x00 in place of the byte on `data_i`. Fetching the image and comparing the result with the stored value are left to the caller.

Top module: `crc_img_engine`

## Requirements
- R1: While `rst_ni` is low and after it is released, `done_o` is 0 and `crc_o` is 0x00000000, and no frame is open.
- R2: For the nine ASCII bytes 0x31..0x39 ("123456789") sent as one frame, `crc_o` is 0xCBF43926. This covers the polynomial, the least-significant-bit-first byte order, the final reversal and the final inversion.
- R3: A beat with `valid_i` and `start_i` high seeds the register with 0xFFFFFFFF before its byte is folded in, so a one-byte frame of 0x00 gives 0xD202EF8D.
- R4: A beat with `mask_i` high is processed as the byte 0x00 whatever `data_i` holds. A frame of four masked beats gives 0x2144DF1C.
- R5: `done_o` is high for exactly the cycle after an accepted beat that carries `last_i`, and in no other cycle.
- R6: A beat with `valid_i` high and `start_i` low while no frame is open is ignored: it raises no `done_o` and does not change `crc_o`.
- R7: Cycles with `valid_i` low do not advance the frame, even when `start_i`, `last_i`, `mask_i` or `data_i` toggle. Gaps inside a frame leave the result unchanged.
- R8: A start beat inside an open frame discards the partial sum and begins a new frame with that byte.
- R9: `crc_o` keeps the last result until the next `done_o` pulse.
- R10: Beats may arrive on every clock, and a new frame may start in the cycle right after the last beat of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat qualifier |
| start_i | input | 1 | Beat is the first byte of a frame |
| last_i | input | 1 | Beat is the final byte of a frame |
| mask_i | input | 1 | Use 0x00 in place of this beat's byte (stored checksum field) |
| data_i | input | 8 | Image byte |
| crc_o | output | 32 | Final checksum of the last completed frame |
| done_o | output | 1 | One-cycle pulse when `crc_o` is updated |

## Verification
The bench builds the engine with its default parameters: an 8-bit beat, the 32-bit polynomial 0x04C11DB7, seed 0xFFFFFFFF, output reflection on and output inversion with 0xFFFFFFFF. With these settings the results can be compared with published CRC-32 check values (the nine-digit string, a single zero byte, four zero bytes). A reference model in the bench, written in the right-shifting reflected form, predicts every beat of mixed frames. Those frames include orphan beats, restarts, masked bytes inside a frame, back-to-back frames, and gaps in which the control inputs toggle.

// File: rtl/crc_img_pkg.sv
package crc_img_pkg;

  localparam int unsigned CrcWDef  = 32;
  localparam int unsigned DataWDef = 8;
  localparam logic [31:0] PolyDef  = 32'h04C1_1DB7;
  localparam logic [31:0] InitDef  = 32'hFFFF_FFFF;
  localparam logic [31:0] XorDef   = 32'hFFFF_FFFF;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } frame_st_e;

endpackage

// File: rtl/crc_img_step.sv
// Folds one beat into the register: DATA_W bit-steps unrolled, data bit 0 first.
module crc_img_step #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0]  seed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  next_o
);

  localparam int unsigned NumStages = DATA_W + 1;

  logic [CRC_W-1:0] stage [NumStages];

  assign stage[0] = seed_i;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    logic             fb;
    logic [CRC_W-1:0] shifted;
    assign fb         = stage[gi][CRC_W-1] ^ data_i[gi];
    assign shifted    = {stage[gi][CRC_W-2:0], 1'b0};
    assign stage[gi+1] = fb ? (shifted ^ POLY) : shifted;
  end

  assign next_o = stage[DATA_W];

endmodule

// File: rtl/crc_img_final.sv
// Output stage: optional bit reversal, then inversion mask.
module crc_img_final #(
  parameter int unsigned CRC_W = 32,
  parameter bit          REFLECT_OUT = 1'b1,
  parameter logic [CRC_W-1:0] XOR_OUT = 32'hFFFF_FFFF
) (
  input  logic [CRC_W-1:0] crc_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] ordered;

  if (REFLECT_OUT) begin : g_reflect
    for (genvar gi = 0; gi < CRC_W; gi++) begin : g_rev
      assign ordered[gi] = crc_i[CRC_W-1-gi];
    end
  end else begin : g_plain
    assign ordered = crc_i;
  end

  assign crc_o = ordered ^ XOR_OUT;

endmodule

// File: rtl/crc_img_seq.sv
// Frame sequencer: beat acceptance, running register, result and done pulse.
module crc_img_seq
  import crc_img_pkg::*;
#(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             start_i,
  input  logic             last_i,
  output logic [CRC_W-1:0] seed_o,
  input  logic [CRC_W-1:0] next_i,
  input  logic [CRC_W-1:0] fin_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o
);

  frame_st_e        st_q, st_d;
  logic [CRC_W-1:0] run_q;
  logic [CRC_W-1:0] res_q;
  logic             done_q;
  logic             accept;
  logic             closing;

  assign accept  = valid_i && (start_i || (st_q == ST_OPEN));
  assign closing = accept && last_i;
  assign seed_o  = start_i ? INIT : run_q;

  always_comb begin
    st_d = st_q;
    if (accept) st_d = last_i ? ST_IDLE : ST_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      run_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= closing;
      if (accept)  run_q <= next_i;
      if (closing) res_q <= fin_i;
    end
  end

  assign crc_o  = res_q;
  assign done_o = done_q;

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && last_i && accept)); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(crc_o)); // R9

  AST_ORPHAN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && st_q == ST_IDLE) |=> (!done_o && $stable(run_q))); // R6

  AST_GAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(run_q) && $stable(st_q) && !done_o)); // R7

endmodule

// File: rtl/crc_img_engine.sv
module crc_img_engine
  import crc_img_pkg::*;
#(
  parameter int unsigned CRC_W  = CrcWDef,
  parameter int unsigned DATA_W = DataWDef,
  parameter logic [CRC_W-1:0] POLY    = PolyDef,
  parameter logic [CRC_W-1:0] INIT    = InitDef,
  parameter logic [CRC_W-1:0] XOR_OUT = XorDef,
  parameter bit REFLECT_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              mask_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o
);

  logic [DATA_W-1:0] byte_eff;
  logic [CRC_W-1:0]  seed;
  logic [CRC_W-1:0]  next;
  logic [CRC_W-1:0]  fin;

  // Stored checksum field counts as zero.
  assign byte_eff = mask_i ? '0 : data_i;

  crc_img_step #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) i_step (
    .seed_i(seed),
    .data_i(byte_eff),
    .next_o(next)
  );

  crc_img_final #(
    .CRC_W      (CRC_W),
    .REFLECT_OUT(REFLECT_OUT),
    .XOR_OUT    (XOR_OUT)
  ) i_final (
    .crc_i(next),
    .crc_o(fin)
  );

  crc_img_seq #(
    .CRC_W(CRC_W),
    .INIT (INIT)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .start_i(start_i),
    .last_i (last_i),
    .seed_o (seed),
    .next_i (next),
    .fin_i  (fin),
    .crc_o  (crc_o),
    .done_o (done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!done_o && crc_o == '0)); // R1

endmodule

// File: tb/test_crc_img_engine.sv
module test_crc_img_engine;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        start_i = 1'b0;
  logic        last_i = 1'b0;
  logic        mask_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [31:0] crc_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  // Reference model, right-shifting reflected formulation.
  logic        mdl_open = 1'b0;
  logic [31:0] mdl_reg  = '0;
  logic [31:0] mdl_out  = '0;
  logic        mdl_done = 1'b0;

  always #2 clk_i = ~clk_i;

  crc_img_engine i_crc_img_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .start_i(start_i),
    .last_i (last_i),
    .mask_i (mask_i),
    .data_i (data_i),
    .crc_o  (crc_o),
    .done_o (done_o)
  );

  // {start, last, mask, data}
  localparam int NV = 22;
  localparam logic [10:0] VEC [NV] = '{
    {3'b000, 8'hAA}, {3'b010, 8'h55},
    {3'b100, 8'h31}, {3'b000, 8'h32}, {3'b000, 8'h33}, {3'b000, 8'h34},
    {3'b000, 8'h35}, {3'b000, 8'h36}, {3'b000, 8'h37}, {3'b000, 8'h38},
    {3'b010, 8'h39},
    {3'b110, 8'h00},
    {3'b101, 8'hDE}, {3'b001, 8'hAD}, {3'b001, 8'hBE}, {3'b011, 8'hEF},
    {3'b100, 8'h11}, {3'b000, 8'h22}, {3'b110, 8'hA5},
    {3'b100, 8'h01}, {3'b001, 8'hFF}, {3'b010, 8'h02}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic mdl_beat(input logic v, input logic s, input logic l,
                          input logic m, input logic [7:0] d);
    logic [7:0] b;
    mdl_done = 1'b0;
    if (v && (s || mdl_open)) begin
      if (s) mdl_reg = 32'hFFFF_FFFF;
      b = m ? 8'h00 : d;
      mdl_reg = mdl_reg ^ {24'h0, b};
      for (int k = 0; k < 8; k++)
        mdl_reg = mdl_reg[0] ? ((mdl_reg >> 1) ^ 32'hEDB8_8320) : (mdl_reg >> 1);
      if (l) begin
        mdl_out  = ~mdl_reg;
        mdl_done = 1'b1;
        mdl_open = 1'b0;
      end else begin
        mdl_open = 1'b1;
      end
    end
  endtask

  // Drive at negedge, check one clock later at negedge.
  task automatic beat(input string tag, input logic v, input logic s, input logic l,
                      input logic m, input logic [7:0] d);
    valid_i = v; start_i = s; last_i = l; mask_i = m; data_i = d;
    mdl_beat(v, s, l, m, d);
    @(negedge clk_i);
    chk({tag, " done"}, {31'h0, done_o}, {31'h0, mdl_done});
    chk({tag, " crc"}, crc_o, mdl_out);
  endtask

  task automatic idle();
    valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0; mask_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1 reset done", {31'h0, done_o}, 32'h0);
    chk("R1 reset crc", crc_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post-reset crc", crc_o, 32'h0);

    // Table walk: R5 R6 R8 R10 via model, fixed values for R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      beat("R5 R10 table", 1'b1, VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0]);
      if (i == 1)  chk("R6 orphan ignored", {31'h0, done_o}, 32'h0);
      if (i == 10) chk("R2 check string", crc_o, 32'hCBF4_3926);
      if (i == 11) chk("R3 seed single zero", crc_o, 32'hD202_EF8D);
      if (i == 15) chk("R4 masked field", crc_o, 32'h2144_DF1C);
      if (i == 18) chk("R8 restart", crc_o, mdl_out);
    end
    idle();
    mdl_beat(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

    // R9: result held over idle cycles, done only one cycle (R5)
    @(negedge clk_i);
    chk("R5 single pulse", {31'h0, done_o}, 32'h0);
    repeat (5) @(negedge clk_i);
    chk("R9 hold", crc_o, mdl_out);

    // R7: gaps with toggling controls inside a frame
    for (int k = 0; k < 9; k++) begin
      beat("R7 gap frame", 1'b1, k == 0, k == 8, 1'b0, 8'h31 + 8'(k));
      valid_i = 1'b0; start_i = 1'b1; last_i = 1'b1; mask_i = 1'b1; data_i = 8'hFF;
      @(negedge clk_i);
      chk("R7 no done in gap", {31'h0, done_o}, 32'h0);
      idle();
    end
    chk("R7 gap result", crc_o, 32'hCBF4_3926);

    // R4: masking inside a frame differs from raw data
    beat("R4 mix a", 1'b1, 1'b1, 1'b0, 1'b1, 8'h5A);
    beat("R4 mix b", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R4 masked equals zero frame", crc_o, 32'h41D9_12FF);
    idle();

    // R1/R6: reset mid-frame closes the frame
    beat("R1 open", 1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
    idle();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 mid reset crc", crc_o, 32'h0);
    chk("R1 mid reset done", {31'h0, done_o}, 32'h0);
    rst_ni = 1'b1;
    mdl_open = 1'b0; mdl_out = '0;
    @(negedge clk_i);
    beat("R6 after reset", 1'b1, 1'b0, 1'b1, 1'b0, 8'h12);
    idle();
    @(negedge clk_i);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule